// File: doc/BRIEF.md
# External Interrupt Entry Controller

This block turns an active-low interrupt request pin into a clean, one-cycle entry command for a small processor's program sequencer. It samples the pin once per instruction cycle through a synchronizer. It accepts a request only after the pin has stayed low for a minimum number of instruction cycles. It then holds the request as pending while the interrupt enable bit of a 4-bit feature-enable register is set.

The sequencer reports, on each instruction-cycle strobe, whether the instruction now ending is a transfer of control or part of a chain of immediate loads. A pending request is taken only at a strobe where neither is reported. When the request is taken, the block asks the sequencer to push the program counter and jump to a fixed handler vector. In the same cycle it clears the enable bit, so a nested entry cannot occur before software enables interrupts again. The return stack, the sequencer and the handler code are outside this block.

Top module: `irq_entry_ctrl`

## Requirements
- R1: The pin is sampled only at `cyc_stb` through two synchronizer stages. A low level seen at two consecutive strobes latches a request. If the pin goes low at strobe k and stays low, `irq_pend` reads 1 after strobe k+3.
- R2: A low level lasting a single strobe sample never produces a request, and `irq_pend` stays 0.
- R3: While bit 1 of `en_bits` is 0, a qualified request is discarded and not remembered. A request that is pending when bit 1 is written to 0 is dropped one strobe later.
- R4: No entry is made at a strobe where `xfer_busy` is 1. The request stays pending.
- R5: No entry is made at a strobe where `ld_chain` is 1, for every strobe of such a chain. The request stays pending.
- R6: At the first strobe where a request is pending, bit 1 is 1, and neither `xfer_busy` nor `ld_chain` is 1, `enter_stb` is 1 for that clock only. `enter_vec` always reads 0x0FF, and `irq_pend` reads 0 after that clock.
- R7: Entry clears bit 1 of `en_bits` and leaves the other three bits unchanged.
- R8: After a request has been latched, no further request is recognised until the synchronized pin has been seen high at a strobe, however long the pin stays low.
- R9: Reset clears `en_bits` and the pending request, and `enter_stb` is 0 while no request is pending.
- R10: A clock with `en_wr` = 1 loads all four bits of `en_bits` from `en_wdata`. This write takes priority over the clearing by entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | One-clock strobe marking the end of an instruction cycle |
| irq_n_pin | input | 1 | Asynchronous active-low interrupt request line |
| xfer_busy | input | 1 | Instruction ending at this strobe is a transfer of control |
| ld_chain | input | 1 | Instruction ending at this strobe belongs to a chain of immediate loads |
| en_wr | input | 1 | Write strobe for the feature-enable register |
| en_wdata | input | 4 | New feature-enable register value |
| enter_stb | output | 1 | Push program counter and jump to the handler vector |
| enter_vec | output | 11 | Handler vector address |
| irq_pend | output | 1 | A qualified request is waiting for entry |
| en_bits | output | 4 | Feature-enable register contents |

## Verification
The bench uses the default parameters: two synchronizer stages, a minimum low width of two strobes, enable bit 1 and an 11-bit vector of 0x0FF. With these values the exact strobe at which a request becomes pending can be checked. So can the one-sample glitch, which is one strobe short of qualifying. An idle clock between strobes shows that nothing moves outside `cyc_stb`. Runs of deferring strobes, enable writes in the clock of a pending request, and a pin held low across an entry probe the ordering and re-arm corners.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int unsigned IRQ_EN_W      = 4;
    localparam int unsigned IRQ_EN_BIT    = 1;
    localparam int unsigned IRQ_MIN_LOW   = 2;
    localparam int unsigned IRQ_SYNC_N    = 2;
    localparam int unsigned IRQ_PC_W      = 11;
    localparam logic [10:0] IRQ_VECTOR    = 11'h0FF;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int unsigned STAGES = irq_entry_pkg::IRQ_SYNC_N
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic pin_n,
    output logic lvl_n
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = stb ? pin_n : sh_q;
        end else begin : g_chain
            always_comb sh_d = stb ? {sh_q[STAGES-2:0], pin_n} : sh_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign lvl_n = sh_q[STAGES-1];

    a_r1_sync_moves_on_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(lvl_n));
endmodule

// File: rtl/irq_width_qual.sv
module irq_width_qual #(
    parameter int unsigned MIN_LOW = irq_entry_pkg::IRQ_MIN_LOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic lvl_n,
    output logic hit
);
    localparam int unsigned CNT_W = irq_entry_pkg::cnt_width(MIN_LOW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (stb) begin
            if (lvl_n) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                if (st_q.cnt == LAST) begin
                    hit        = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{armed: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    a_r2_hit_needs_low_level: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (stb && !lvl_n));
    a_r8_rearm_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(lvl_n));
    a_r8_no_hit_while_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !st_q.armed);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl #(
    parameter int unsigned EN_W     = irq_entry_pkg::IRQ_EN_W,
    parameter int unsigned EN_BIT   = irq_entry_pkg::IRQ_EN_BIT,
    parameter int unsigned MIN_LOW  = irq_entry_pkg::IRQ_MIN_LOW,
    parameter int unsigned SYNC_N   = irq_entry_pkg::IRQ_SYNC_N,
    parameter int unsigned PC_W     = irq_entry_pkg::IRQ_PC_W,
    parameter logic [PC_W-1:0] VECTOR = PC_W'(irq_entry_pkg::IRQ_VECTOR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cyc_stb,
    input  logic            irq_n_pin,
    input  logic            xfer_busy,
    input  logic            ld_chain,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    output logic            enter_stb,
    output logic [PC_W-1:0] enter_vec,
    output logic            irq_pend,
    output logic [EN_W-1:0] en_bits
);
    typedef struct packed {
        logic            pend;
        logic [EN_W-1:0] en;
    } ctl_t;

    ctl_t st_d, st_q;
    logic lvl_n;
    logic hit;
    logic en_on;
    logic safe;

    irq_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (cyc_stb),
        .pin_n (irq_n_pin),
        .lvl_n (lvl_n)
    );

    irq_width_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (cyc_stb),
        .lvl_n (lvl_n),
        .hit   (hit)
    );

    always_comb begin
        st_d      = st_q;
        en_on     = st_q.en[EN_BIT];
        safe      = !xfer_busy && !ld_chain;
        enter_stb = cyc_stb && st_q.pend && en_on && safe;

        // pending survives only while enabled; entry consumes it
        st_d.pend = en_on && (st_q.pend || hit) && !enter_stb;

        if (enter_stb) st_d.en[EN_BIT] = 1'b0;
        if (en_wr)     st_d.en = en_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enter_vec = VECTOR;
    assign irq_pend  = st_q.pend;
    assign en_bits   = st_q.en;

    a_r3_disabled_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
        !en_bits[EN_BIT] |=> !irq_pend);
    a_r4_no_entry_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && xfer_busy) |-> !enter_stb);
    a_r5_no_entry_in_load_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && ld_chain) |-> !enter_stb);
    a_r4_deferred_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && en_bits[EN_BIT] && !enter_stb) |=> irq_pend);
    a_r6_entry_is_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        enter_stb |=> !enter_stb);
    a_r7_entry_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_stb && !en_wr) |=> (!en_bits[EN_BIT] &&
            ((en_bits ^ $past(en_bits)) == (EN_W'(1) << EN_BIT))));
    a_r10_write_loads_all: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_bits == $past(en_wdata)));
endmodule

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] EN_ON  = 4'b1010;
    localparam logic [3:0] EN_CLR = 4'b1000;
    localparam logic [3:0] EN_OFF = 4'b0101;
    localparam int NROWS = 50;

    // row: req[3:0], pin, xfer, chain, wr, wdata[3:0], exp_enter, exp_pend, exp_en[3:0]
    function automatic logic [17:0] mk(input logic [3:0] req, input logic pin,
                                       input logic xf, input logic ch, input logic wr,
                                       input logic [3:0] wd, input logic ee,
                                       input logic ep, input logic [3:0] een);
        return {req, pin, xf, ch, wr, wd, ee, ep, een};
    endfunction

    localparam logic [17:0] VEC [NROWS] = '{
        // R10 setup: enable write
        mk(4'd10,1,0,0,1,EN_ON ,0,0,EN_ON ),
        // R1 two-strobe low pulse, entry and R7 clearing
        mk(4'd1 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd1 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd1 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd1 ,1,0,0,0,4'h0  ,0,1,EN_ON ),
        mk(4'd7 ,1,0,0,0,4'h0  ,1,0,EN_CLR),
        mk(4'd10,1,0,0,1,EN_ON ,0,0,EN_ON ),
        // R2 single-sample glitch
        mk(4'd2 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd2 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd2 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd2 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd2 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        // R4 / R5 deferral
        mk(4'd4 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd4 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd4 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd4 ,1,0,0,0,4'h0  ,0,1,EN_ON ),
        mk(4'd4 ,1,1,0,0,4'h0  ,0,1,EN_ON ),
        mk(4'd5 ,1,0,1,0,4'h0  ,0,1,EN_ON ),
        mk(4'd5 ,1,0,1,0,4'h0  ,0,1,EN_ON ),
        mk(4'd6 ,1,0,0,0,4'h0  ,1,0,EN_CLR),
        mk(4'd10,1,0,0,1,EN_ON ,0,0,EN_ON ),
        // R3 disabled request discarded
        mk(4'd3 ,0,0,0,1,EN_OFF,0,0,EN_OFF),
        mk(4'd3 ,0,0,0,0,4'h0  ,0,0,EN_OFF),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_OFF),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_OFF),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_OFF),
        mk(4'd3 ,1,0,0,1,EN_ON ,0,0,EN_ON ),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        // R8 pin held low across entry
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,1,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,1,0,EN_CLR),
        mk(4'd8 ,0,0,0,1,EN_ON ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd8 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        // R3 pending request dropped by disabling write
        mk(4'd3 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd3 ,0,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_ON ),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,1,EN_ON ),
        mk(4'd3 ,1,1,0,1,EN_OFF,0,1,EN_OFF),
        mk(4'd3 ,1,0,0,0,4'h0  ,0,0,EN_OFF),
        mk(4'd3 ,1,0,0,1,EN_ON ,0,0,EN_ON )
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_stb = 1'b0;
    logic       irq_n_pin = 1'b1;
    logic       xfer_busy = 1'b0;
    logic       ld_chain = 1'b0;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = 4'h0;
    logic       enter_stb;
    logic [10:0] enter_vec;
    logic       irq_pend;
    logic [3:0] en_bits;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    irq_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_n_pin(irq_n_pin),
        .xfer_busy(xfer_busy), .ld_chain(ld_chain), .en_wr(en_wr),
        .en_wdata(en_wdata), .enter_stb(enter_stb), .enter_vec(enter_vec),
        .irq_pend(irq_pend), .en_bits(en_bits)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one instruction cycle: strobe clock followed by an idle clock
    task automatic step(input logic pin, input logic xf, input logic ch,
                        input logic wr, input logic [3:0] wd,
                        output logic ent, output logic pnd, output logic [3:0] enb);
        @(negedge clk);
        irq_n_pin = pin; xfer_busy = xf; ld_chain = ch;
        en_wr = wr; en_wdata = wd; cyc_stb = 1'b1;
        #1 ent = enter_stb;
        @(posedge clk);
        #1 pnd = irq_pend; enb = en_bits;
        @(negedge clk);
        cyc_stb = 1'b0; en_wr = 1'b0; xfer_busy = 1'b0; ld_chain = 1'b0;
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R0 watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic ent, pnd;
        logic [3:0] enb;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state, strobe present but nothing pending
        cyc_stb = 1'b1;
        #1;
        check(9, "reset enter", {15'd0, enter_stb}, 16'd0);
        check(9, "reset pend",  {15'd0, irq_pend},  16'd0);
        check(9, "reset en",    {12'd0, en_bits},   16'd0);
        check(6, "vector",      {5'd0, enter_vec},  16'h00FF);
        @(posedge clk);
        @(negedge clk);
        cyc_stb = 1'b0;
        @(posedge clk);

        for (int i = 0; i < NROWS; i++) begin
            logic [17:0] r;
            r = VEC[i];
            step(r[13], r[12], r[11], r[10], r[9:6], ent, pnd, enb);
            check(int'(r[17:14]), $sformatf("row %0d enter", i), {15'd0, ent}, {15'd0, r[5]});
            check(int'(r[17:14]), $sformatf("row %0d pend", i),  {15'd0, pnd}, {15'd0, r[4]});
            check(int'(r[17:14]), $sformatf("row %0d en", i),    {12'd0, enb}, {12'd0, r[3:0]});
        end

        // R6 vector holds after activity
        check(6, "vector after run", {5'd0, enter_vec}, 16'h00FF);

        // R9 reset drops a pending request and the enable register
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, ent, pnd, enb);
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, ent, pnd, enb);
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, ent, pnd, enb);
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, ent, pnd, enb);
        check(9, "pend before reset", {15'd0, pnd}, 16'd1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(9, "pend after reset", {15'd0, irq_pend}, 16'd0);
        check(9, "en after reset",   {12'd0, en_bits},  16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule